// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits beside a UART transmitter and drives the direction pin of a half-duplex RS-485 transceiver. Loading a byte into the transmit FIFO puts the pin into its transmit level at once. The pin is released one bit time after the stop bit of the final queued character. The release delay is counted on the transmitter's 16x baud tick, so the pin cannot cut off the last stop bit on the wire. The serial shifter, the FIFO storage and the baud divider are outside this block. Their status reaches it as plain inputs.

The block also shapes the transmit interrupt request. With the automatic mode on, the request waits until both the FIFO and the shifter are empty. The CPU therefore cannot turn the bus around while bits are still going out. With the mode off, the block falls back to the classic timing: the request is raised as soon as the FIFO is empty, even while the shifter is still sending. A separate input flips the electrical polarity of the direction pin.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: During and directly after reset, `dir_out` equals `dir_invert` (internal level LOW), and `tx_irq` is 0.
- R2: With `auto_en`=0, `tx_irq` equals the `fifo_empty` value sampled at the previous clock edge, whatever the value of `shift_busy`.
- R3: With `auto_en`=1, `tx_irq` is 1 only when `fifo_empty`=1 and `shift_busy`=0 were both true at the previous clock edge.
- R4: With `auto_en`=1, a `stop_done` pulse while `fifo_empty`=1 starts the release delay. The internal level goes HIGH in the cycle after the 16th `tick16` pulse that follows the start. Ticks that arrive before the start do not count.
- R5: A `stop_done` pulse while `fifo_empty`=0 (back-to-back characters) does not start the release delay, and the pin stays at the transmit level.
- R6: A `fifo_load` pulse during the release delay cancels it. The pin stays at the transmit level however many ticks follow.
- R7: With `auto_en`=1, a `fifo_load` pulse drives the internal level LOW (transmit) in the next cycle.
- R8: `dir_out` is the internal level XOR `dir_invert`, and it follows `dir_invert` without a clock edge.
- R9: With `auto_en`=0, the internal level is held LOW, and `stop_done` and `tick16` have no effect on `dir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | Enables automatic direction control and deferred interrupt |
| dir_invert | input | 1 | Inverts the polarity of `dir_out` |
| fifo_load | input | 1 | One-cycle strobe: a byte was written into the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| shift_busy | input | 1 | Transmit shift register holds data still being sent |
| stop_done | input | 1 | One-cycle pulse at the end of a character's stop bit |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| dir_out | output | 1 | Transceiver direction pin (LOW = transmit before inversion) |
| tx_irq | output | 1 | Registered transmit interrupt request |

## Verification
The interrupt path is driven through all combinations of enable, FIFO-empty and shifter-busy. This separates the classic timing, which fires while the shifter still runs, from the deferred timing, which waits for the shifter. The release path is tested in several ways:
- Ticks arrive before the stop-bit pulse, then exactly 15 and 16 ticks follow. This pins the delay to one bit time counted from the last stop bit.
- A stop-bit pulse comes while the FIFO still holds data. This shows that back-to-back characters never release the pin.
- A load strobe comes in the middle of the delay, and the mode is turned off. Both tell cancellation apart from a delayed release.

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic dir_invert,
  input  logic fifo_load,
  input  logic fifo_empty,
  input  logic shift_busy,
  input  logic stop_done,
  input  logic tick16,
  output logic dir_out,
  output logic tx_irq
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic          raw_hi;
  logic          counting;
  logic [CW-1:0] cnt;
  logic          irq_q;

  wire irq_cond = auto_en ? (fifo_empty && !shift_busy) : fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_hi   <= 1'b0;
      counting <= 1'b0;
      cnt      <= '0;
    end else if (!auto_en || fifo_load) begin
      raw_hi   <= 1'b0;
      counting <= 1'b0;
      cnt      <= '0;
    end else if (stop_done && fifo_empty) begin
      counting <= 1'b1;
      cnt      <= '0;
    end else if (counting && tick16) begin
      if (cnt == LAST) begin
        raw_hi   <= 1'b1;
        counting <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_cond;
  end

  assign dir_out = raw_hi ^ dir_invert;
  assign tx_irq  = irq_q;
endmodule

module rs485_dir_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_en,
  input logic fifo_load,
  input logic fifo_empty,
  input logic shift_busy,
  input logic tick16,
  input logic tx_irq,
  input logic raw_hi
);
  p_irq_std_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (tx_irq == $past(fifo_empty)));

  p_irq_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && shift_busy) |=> !tx_irq);

  p_release_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_hi) |-> ($past(tick16) && $past(auto_en)));

  p_load_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_load) |=> !raw_hi);

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !raw_hi);
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .fifo_load(fifo_load),
  .fifo_empty(fifo_empty), .shift_busy(shift_busy), .tick16(tick16),
  .tx_irq(tx_irq), .raw_hi(raw_hi)
);

// File: tb/test_rs485_dir_ctrl.sv
module test_rs485_dir_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, dir_invert = 1'b0, fifo_load = 1'b0, fifo_empty = 1'b1;
  logic shift_busy = 1'b0, stop_done = 1'b0, tick16 = 1'b0;
  logic dir_out, tx_irq;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rs485_dir_ctrl i_rs485_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dir_invert(dir_invert),
    .fifo_load(fifo_load), .fifo_empty(fifo_empty), .shift_busy(shift_busy),
    .stop_done(stop_done), .tick16(tick16), .dir_out(dir_out), .tx_irq(tx_irq)
  );

  // {auto_en, fifo_empty, shift_busy, expected tx_irq}
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0101, 4'b0111, 4'b0010,
    4'b1110, 4'b1101, 4'b1000, 4'b1010
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1'b1; step();
      tick16 = 1'b0; step();
    end
  endtask

  task automatic pulse_stop();
    stop_done = 1'b1; step(); stop_done = 1'b0;
  endtask

  task automatic pulse_load();
    fifo_load = 1'b1; step(); fifo_load = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    dir_invert = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 dir_out in reset", dir_out, 1'b1);
    check("R1 tx_irq in reset", tx_irq, 1'b0);
    dir_invert = 1'b0;
    #1 check("R1 dir_out low in reset", dir_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // interrupt timing table (R2, R3)
    for (int i = 0; i < 8; i++) begin
      {auto_en, fifo_empty, shift_busy} = VEC[i][3:1];
      step();
      check(VEC[i][3] ? "R3 deferred irq" : "R2 standard irq", tx_irq, VEC[i][0]);
    end

    // R4: release exactly 16 ticks after stop with empty FIFO
    auto_en = 1'b1; fifo_empty = 1'b0; shift_busy = 1'b1;
    pulse_load();
    check("R7 load drives transmit level", dir_out, 1'b0);
    ticks(3);
    fifo_empty = 1'b1; shift_busy = 1'b0;
    pulse_stop();
    check("R4 low right after stop", dir_out, 1'b0);
    ticks(15);
    check("R4 low after 15 ticks", dir_out, 1'b0);
    tick16 = 1'b1; step(); tick16 = 1'b0;
    check("R4 high after 16th tick", dir_out, 1'b1);

    // R8: polarity inversion without clock
    dir_invert = 1'b1;
    #1 check("R8 inverted released level", dir_out, 1'b0);
    dir_invert = 1'b0;
    #1 check("R8 restored polarity", dir_out, 1'b1);

    // R7: load after release
    @(negedge clk);
    pulse_load();
    check("R7 load after release", dir_out, 1'b0);

    // R6: load during delay cancels
    pulse_stop();
    ticks(10);
    pulse_load();
    ticks(20);
    check("R6 cancelled delay stays low", dir_out, 1'b0);

    // R5: stop with non-empty FIFO does not start delay
    fifo_empty = 1'b0;
    pulse_stop();
    ticks(20);
    check("R5 back-to-back stays low", dir_out, 1'b0);
    fifo_empty = 1'b1;

    // R9: disabled mode ignores stop and ticks
    auto_en = 1'b0;
    step();
    pulse_stop();
    ticks(20);
    check("R9 disabled stays low", dir_out, 1'b0);

    // R9: disabling after release pulls level low
    auto_en = 1'b1;
    pulse_stop();
    ticks(16);
    check("R4 release again", dir_out, 1'b1);
    auto_en = 1'b0;
    step();
    check("R9 disable clears released level", dir_out, 1'b0);

    // R2 vs R3: busy shifter with empty FIFO
    fifo_empty = 1'b1; shift_busy = 1'b1;
    step();
    check("R2 irq while shifting", tx_irq, 1'b1);
    auto_en = 1'b1;
    step();
    check("R3 irq held while shifting", tx_irq, 1'b0);
    shift_busy = 1'b0;
    step();
    check("R3 irq once shifter empty", tx_irq, 1'b1);

    finish_run();
  end
endmodule